// File: doc/BRIEF.md
# Multiplierless Pipelined Constant FIR

This block is a streaming direct-form FIR filter whose tap weights are fixed when it is built. Every tap product is made from copies of the sample that are shifted and then added together. No general multiplier is used. The shift-add network for a tap is generated from the set bits of that tap's weight. A negative weight is handled by negating the positive product.

Each product is captured in a register before it enters the summation tree. Every level of the pairwise adder tree also ends in a register. A value that is still settling in one stage therefore never reaches the adders of the next stage. A source presents a signed sample with a one-cycle valid strobe. Exactly one filtered sample appears, with its own strobe, after a fixed number of clock edges. Samples may arrive every cycle or with gaps of any length. The delay line advances only on accepted samples.

Top module: `shiftadd_fir`

## Requirements
- R1: Each output equals the sum, over taps k = 0..NUM_TAPS-1, of weight k times the sample accepted k strobes earlier. Tap 0 is the sample accepted with the same strobe. Samples and weights are signed two's complement.
- R2: out_valid is high for exactly one cycle per accepted sample. That cycle follows the LAT-th rising edge, counting the edge that sampled in_valid, where LAT = 1 + ceil(log2(NUM_TAPS)). With the default five taps, LAT = 4.
- R3: A synchronous reset clears the delay line and every pipeline register. Samples accepted before the reset therefore contribute zero to later outputs, and out_data reads 0 after reset.
- R4: While reset is applied, and until the first accepted sample has crossed all LAT stages, out_valid stays low.
- R5: Between output strobes, out_data keeps the value of the most recent output.
- R6: The output width is DATA_W + COEF_W + ceil(log2(NUM_TAPS)). Extreme samples (-128, 127) and extreme weights (-128, 127) produce exact results with no wrap.
- R7: The default weights are 127, -5, 12, -128, 1 for taps 0..4. A single unit sample followed by zeros produces exactly this sequence, including the most negative weight code.
- R8: Samples presented on every cycle and samples presented with idle gaps between them yield the same filtered values for the same sample sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; one sample is accepted per cycle it is high |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Strobe for one filtered sample |
| out_data | output | DATA_W+COEF_W+clog2(NUM_TAPS) | Signed filtered sample |

## Verification
The assertions assume that in_valid is a plain per-cycle strobe with no back-pressure. They also assume that in_data is any DATA_W-bit two's complement value, so the output magnitude can never exceed 2^(DATA_W-1) times the sum of the weight magnitudes. The stimulus stays inside these assumptions. It drives only whole strobes on falling edges, and every sample is drawn from the full signed input range. Reset is applied only after the pipeline has drained. The hold and fill checks therefore never see an output that is still in flight across a reset.

// File: rtl/fir_pkg.sv
package fir_pkg;

    // number of values present at a given level of the pairwise tree
    function automatic int lvl_nodes(input int taps, input int lvl);
        int n;
        n = taps;
        for (int i = 0; i < lvl; i++) begin
            n = (n + 1) / 2;
        end
        return n;
    endfunction

    function automatic longint abs_val(input longint v);
        return (v < 0) ? -v : v;
    endfunction

endpackage

// File: rtl/fir_const_mult.sv
// Product of a sample and a fixed weight, built only from shifts and adds.
module fir_const_mult #(
    parameter int               W_IN   = 8,
    parameter int               COEF_W = 8,
    parameter int               ACC_W  = 19,
    parameter logic [COEF_W-1:0] COEF  = '0
) (
    input  logic [W_IN-1:0]  x_i,
    output logic [ACC_W-1:0] p_o
);
    localparam bit               NEG = COEF[COEF_W-1];
    localparam logic [COEF_W-1:0] MAG = NEG ? (~COEF + 1'b1) : COEF;

    logic [ACC_W-1:0]            xe;
    logic [COEF_W:0][ACC_W-1:0]  part;

    assign xe      = {{(ACC_W-W_IN){x_i[W_IN-1]}}, x_i};
    assign part[0] = '0;

    for (genvar b = 0; b < COEF_W; b++) begin : g_bit
        if (MAG[b]) begin : g_set
            assign part[b+1] = part[b] + (xe << b);
        end else begin : g_clr
            assign part[b+1] = part[b];
        end
    end

    if (NEG) begin : g_neg
        assign p_o = -part[COEF_W];
    end else begin : g_pos
        assign p_o = part[COEF_W];
    end
endmodule

// File: rtl/fir_sum_level.sv
// One level of the pairwise adder tree; an odd last value passes through.
module fir_sum_level #(
    parameter  int N_IN  = 5,
    parameter  int ACC_W = 19,
    localparam int N_OUT = (N_IN + 1) / 2
) (
    input  logic [N_IN-1:0][ACC_W-1:0]  a_i,
    output logic [N_OUT-1:0][ACC_W-1:0] s_o
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_node
        if (2*i + 1 < N_IN) begin : g_pair
            assign s_o[i] = a_i[2*i] + a_i[2*i+1];
        end else begin : g_pass
            assign s_o[i] = a_i[2*i];
        end
    end
endmodule

// File: rtl/shiftadd_fir.sv
module shiftadd_fir
    import fir_pkg::*;
#(
    parameter  int DATA_W   = 8,
    parameter  int COEF_W   = 8,
    parameter  int NUM_TAPS = 5,
    parameter  logic [NUM_TAPS-1:0][COEF_W-1:0] COEFS =
        {8'h01, 8'h80, 8'h0C, 8'hFB, 8'h7F},
    localparam int ACC_W    = DATA_W + COEF_W + $clog2(NUM_TAPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);
    localparam int LVLS = $clog2(NUM_TAPS);

    typedef logic [NUM_TAPS-1:0][ACC_W-1:0] vec_t;

    typedef struct packed {
        logic [NUM_TAPS-1:1][DATA_W-1:0] dl;   // dl[k]: sample accepted k strobes ago
        logic [LVLS:0]                   vld;  // vld[0]: products, vld[l]: tree level l
        vec_t [LVLS:0]                   lvl;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_TAPS-1:0][DATA_W-1:0] taps_w;
    vec_t                            prod_w;
    vec_t                            sum_w [LVLS:1];

    assign taps_w[0] = in_data;
    for (genvar i = 1; i < NUM_TAPS; i++) begin : g_tap
        assign taps_w[i] = st_q.dl[i];
    end

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_mul
        fir_const_mult #(
            .W_IN  (DATA_W),
            .COEF_W(COEF_W),
            .ACC_W (ACC_W),
            .COEF  (COEFS[i])
        ) i_mul (
            .x_i(taps_w[i]),
            .p_o(prod_w[i])
        );
    end

    for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
        localparam int NI = lvl_nodes(NUM_TAPS, l - 1);
        localparam int NO = lvl_nodes(NUM_TAPS, l);
        logic [NO-1:0][ACC_W-1:0] s;
        vec_t                     pad;

        fir_sum_level #(
            .N_IN (NI),
            .ACC_W(ACC_W)
        ) i_lvl (
            .a_i(st_q.lvl[l-1][NI-1:0]),
            .s_o(s)
        );

        always_comb begin
            pad          = '0;
            pad[NO-1:0]  = s;
        end
        assign sum_w[l] = pad;
    end

    always_comb begin
        st_d        = st_q;
        st_d.vld[0] = in_valid;
        if (in_valid) begin
            st_d.lvl[0] = prod_w;
            st_d.dl[1]  = in_data;
            for (int i = 2; i < NUM_TAPS; i++) begin
                st_d.dl[i] = st_q.dl[i-1];
            end
        end
        for (int l = 1; l <= LVLS; l++) begin
            st_d.vld[l] = st_q.vld[l-1];
            if (st_q.vld[l-1]) begin
                st_d.lvl[l] = sum_w[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld[LVLS];
    assign out_data  = st_q.lvl[LVLS][0];
endmodule

// File: rtl/shiftadd_fir_chk.sv
module shiftadd_fir_chk
    import fir_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int COEF_W   = 8,
    parameter int NUM_TAPS = 5,
    parameter logic [NUM_TAPS-1:0][COEF_W-1:0] COEFS =
        {8'h01, 8'h80, 8'h0C, 8'hFB, 8'h7F},
    parameter int ACC_W    = 19
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_data
);
    localparam int LAT = $clog2(NUM_TAPS) + 1;

    function automatic longint bound_f();
        longint s;
        s = 0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            s += abs_val(longint'($signed(COEFS[i])));
        end
        return s * (longint'(1) << (DATA_W - 1));
    endfunction

    localparam longint BOUND = bound_f();

    logic [LAT-1:0] sh_q;
    int             cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= 0;
        end else begin
            sh_q  <= {sh_q[LAT-2:0], in_valid};
            cnt_q <= (cnt_q < LAT) ? cnt_q + 1 : cnt_q;
        end
    end

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cnt_q >= LAT));                                  // R4
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == sh_q[LAT-1]);                                      // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != 0 && !out_valid) |-> $stable(out_data));              // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (longint'($signed(out_data)) <= BOUND &&
                       longint'($signed(out_data)) >= -BOUND));         // R6
endmodule

bind shiftadd_fir shiftadd_fir_chk #(
    .DATA_W  (DATA_W),
    .COEF_W  (COEF_W),
    .NUM_TAPS(NUM_TAPS),
    .COEFS   (COEFS),
    .ACC_W   (ACC_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/test_shiftadd_fir.sv
module test_shiftadd_fir;
    localparam int DW  = 8;
    localparam int NT  = 5;
    localparam int AW  = 19;
    localparam int LAT = 4;
    localparam int CM [NT] = '{127, -5, 12, -128, 1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [AW-1:0] out_data;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    last_out = 0;
    bit    done = 1'b0;
    int    m_dl [NT];
    int    exp_q [$];
    int    cyc_q [$];
    string tag_q [$];

    shiftadd_fir i_shiftadd_fir (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // scoreboard driver: present one sample and push its expected result
    task automatic send(input int x, input string tag);
        int e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(x);
        for (int i = NT - 1; i > 0; i--) m_dl[i] = m_dl[i-1];
        m_dl[0] = x;
        e = 0;
        for (int i = 0; i < NT; i++) e += CM[i] * m_dl[i];
        exp_q.push_back(e);
        cyc_q.push_back(cyc + LAT);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) idle(1);
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        idle(2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        idle(2);
        check(out_valid == 1'b0, "R4", int'(out_valid), 0);
        check(out_data == '0, "R3", int'($signed(out_data)), 0);
        for (int i = 0; i < NT; i++) m_dl[i] = 0;
        last_out = 0;
        rst = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", 1, 0);
                end else begin
                    int    e, c;
                    string t;
                    e = exp_q.pop_front();
                    c = cyc_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'($signed(out_data)) == e, t, int'($signed(out_data)), e);
                    check(cyc == c, "R2", cyc, c);
                end
                last_out = int'($signed(out_data));
            end else begin
                check(int'($signed(out_data)) == last_out, "R5",
                      int'($signed(out_data)), last_out);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NT; i++) m_dl[i] = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R4", int'(out_valid), 0);
        check(out_data == '0, "R3", int'($signed(out_data)), 0);
        rst = 1'b0;
        idle(6);
        check(out_valid == 1'b0, "R4", int'(out_valid), 0);

        // R7: unit impulse reproduces the weights in tap order
        send(1, "R7");
        for (int i = 0; i < NT; i++) send(0, "R7");
        drain();

        // R6: most negative sample through every weight
        send(-128, "R6");
        for (int i = 0; i < NT; i++) send(0, "R6");
        // R6: sign-matched extremes give the largest magnitude
        for (int r = 0; r < 2; r++) begin
            for (int i = NT - 1; i >= 0; i--) send(CM[i] < 0 ? -128 : 127, "R6");
        end
        for (int i = 0; i < NT + 1; i++) send(-128, "R6");
        for (int i = 0; i < NT + 1; i++) send(127, "R6");
        drain();

        // R8 / R1: back-to-back random samples
        for (int i = 0; i < 40; i++) send(int'($urandom_range(255)) - 128, "R8");
        idle(1);
        // R8 / R1: sparse samples with gaps
        for (int i = 0; i < 30; i++) begin
            send(int'($urandom_range(255)) - 128, "R1");
            idle(int'($urandom_range(3)));
        end
        drain();

        // R3: history before a reset must not leak into later outputs
        for (int i = 0; i < NT; i++) send(100 - 37 * i, "R1");
        drain();
        do_reset();
        idle(3);
        send(1, "R3");
        for (int i = 0; i < NT; i++) send(0, "R3");
        drain();

        idle(4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule